// File: doc/BRIEF.md
# Handshaked Word Clock-Domain Synchronizer

This block moves a multi-bit data word from a source clock domain into an unrelated destination clock domain without synchronizing the data bits one by one. When the source offers a word with a valid strobe and the block is idle, the word is captured into a source-side register and a single toggle event is flipped. That toggle is the only signal that passes through a flip-flop synchronizer chain into the destination domain.

When the destination domain sees the synchronized toggle change, it samples the held word, drives it on the output with a one-cycle valid pulse, and flips an acknowledge toggle. The acknowledge toggle returns through a mirrored synchronizer chain to the source domain. Until it arrives, the block reports busy and ignores further offers, so the held word cannot change while it is being sampled across the boundary. The word width (default 16 bits) and the synchronizer depth (default 2 flip-flops, raised to 2 if set lower) are parameters.

The block suits configuration values, counters and status words that change rarely compared with the round-trip time. It is not a queue: a new word can only be taken once the previous crossing has been acknowledged.

Top module: `word_cdc_sync`

## Requirements
- R1: After both resets, `dst_data_o` is zero, `dst_valid_o` is low and `src_busy_o` is low.
- R2: Every accepted word appears on `dst_data_o` together with `dst_valid_o` high for exactly one destination clock cycle.
- R3: A word is accepted on any source clock edge at which `src_valid_i` is high and `src_busy_o` is low, including the first cycle after busy falls; `src_busy_o` is high in the source cycle following an acceptance.
- R4: An offer made while `src_busy_o` is high is ignored: it is never delivered and the held word is unchanged.
- R5: `dst_data_o` changes only in a cycle where `dst_valid_o` is high and holds its value otherwise.
- R6: Accepted words are delivered in acceptance order, none lost and none duplicated.
- R7: `src_busy_o` falls only after the destination has issued the delivery pulse for the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| src_data_i | input | WIDTH | Word offered by the source |
| src_valid_i | input | 1 | Offer strobe for `src_data_i` |
| src_busy_o | output | 1 | High while a crossing is in flight; offers are ignored |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| dst_data_o | output | WIDTH | Last word delivered into the destination domain |
| dst_valid_o | output | 1 | One-cycle pulse marking a newly delivered word |

## Verification
The interesting coincidence is the acknowledge arriving in the same source cycle that a new offer is present: busy falls and the next word must be taken at once, with no idle cycle and no double capture. The bench provokes this by holding the valid strobe high for hundreds of cycles with data changing every cycle, on source and destination clocks of unrelated periods, so the acknowledge lands at varying phases. Each cycle the driver decides from the busy output alone whether the offer is taken and queues only those words; the monitor compares every delivery pulse against the queue, and the driver also checks that busy rises after each take and never falls before the matching delivery.

// File: rtl/wcdc_pkg.sv
`timescale 1ns/1ps
package wcdc_pkg;
  localparam int unsigned MIN_STAGES = 2;

  // a toggle event is seen when the newest sample differs from the last
  function automatic logic tgl_event(input logic cur, input logic prev);
    return cur ^ prev;
  endfunction
endpackage

// File: rtl/wcdc_sync_chain.sv
`timescale 1ns/1ps
module wcdc_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import wcdc_pkg::*;

  localparam int unsigned DEPTH = (STAGES < MIN_STAGES) ? MIN_STAGES : STAGES;

  logic [DEPTH-1:0] stg_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/wcdc_src.sv
`timescale 1ns/1ps
module wcdc_src #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  input  logic             ack_sync_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             req_tgl_o,
  output logic [WIDTH-1:0] hold_o
);
  logic             req_tgl_q;
  logic [WIDTH-1:0] hold_q;

  // busy while the returned acknowledge lags the request toggle
  assign busy_o   = req_tgl_q ^ ack_sync_i;
  assign accept_o = valid_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_q <= 1'b0;
      hold_q    <= '0;
    end else if (accept_o) begin
      req_tgl_q <= ~req_tgl_q;
      hold_q    <= data_i;
    end
  end

  assign req_tgl_o = req_tgl_q;
  assign hold_o    = hold_q;
endmodule

// File: rtl/wcdc_dst.sv
`timescale 1ns/1ps
module wcdc_dst #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_sync_i,
  input  logic [WIDTH-1:0] hold_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o,
  output logic             ack_tgl_o
);
  import wcdc_pkg::*;

  logic             req_prev_q;
  logic             ack_tgl_q;
  logic             valid_q;
  logic [WIDTH-1:0] data_q;
  logic             evt;

  assign evt = tgl_event(req_sync_i, req_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_prev_q <= 1'b0;
      ack_tgl_q  <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      req_prev_q <= req_sync_i;
      valid_q    <= evt;
      if (evt) begin
        // hold_i is static while the request toggle is in flight
        data_q    <= hold_i;
        ack_tgl_q <= ~ack_tgl_q;
      end
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign ack_tgl_o = ack_tgl_q;
endmodule

// File: rtl/word_cdc_sync.sv
`timescale 1ns/1ps
module word_cdc_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             src_clk_i,
  input  logic             src_rst_ni,
  input  logic [WIDTH-1:0] src_data_i,
  input  logic             src_valid_i,
  output logic             src_busy_o,
  input  logic             dst_clk_i,
  input  logic             dst_rst_ni,
  output logic [WIDTH-1:0] dst_data_o,
  output logic             dst_valid_o
);
  logic             req_tgl;
  logic             req_sync;
  logic             ack_tgl;
  logic             ack_sync;
  logic             src_accept;
  logic [WIDTH-1:0] hold_word;

  wcdc_src #(.WIDTH(WIDTH)) u_src (
    .clk_i      (src_clk_i),
    .rst_ni     (src_rst_ni),
    .data_i     (src_data_i),
    .valid_i    (src_valid_i),
    .ack_sync_i (ack_sync),
    .busy_o     (src_busy_o),
    .accept_o   (src_accept),
    .req_tgl_o  (req_tgl),
    .hold_o     (hold_word)
  );

  wcdc_sync_chain #(.STAGES(STAGES)) u_req_sync (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .d_i    (req_tgl),
    .q_o    (req_sync)
  );

  wcdc_dst #(.WIDTH(WIDTH)) u_dst (
    .clk_i      (dst_clk_i),
    .rst_ni     (dst_rst_ni),
    .req_sync_i (req_sync),
    .hold_i     (hold_word),
    .data_o     (dst_data_o),
    .valid_o    (dst_valid_o),
    .ack_tgl_o  (ack_tgl)
  );

  wcdc_sync_chain #(.STAGES(STAGES)) u_ack_sync (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .d_i    (ack_tgl),
    .q_o    (ack_sync)
  );
endmodule

// File: rtl/wcdc_checker.sv
`timescale 1ns/1ps
module wcdc_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             src_clk_i,
  input logic             src_rst_ni,
  input logic             dst_clk_i,
  input logic             dst_rst_ni,
  input logic             src_valid_i,
  input logic             src_busy_o,
  input logic             src_accept,
  input logic             ack_sync,
  input logic [WIDTH-1:0] hold_word,
  input logic [WIDTH-1:0] dst_data_o,
  input logic             dst_valid_o
);
  p_single_pulse_r2: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    dst_valid_o |=> !dst_valid_o);

  p_busy_after_accept_r3: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (src_valid_i && !src_busy_o) |=> src_busy_o);

  p_hold_stable_r4: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    src_busy_o |=> $stable(hold_word));

  p_no_accept_busy_r4: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    src_busy_o |-> !src_accept);

  p_out_stable_r5: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    !$stable(dst_data_o) |-> dst_valid_o);

  p_busy_release_r7: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    $fell(src_busy_o) |-> !$stable(ack_sync));
endmodule

bind word_cdc_sync wcdc_checker #(.WIDTH(WIDTH)) u_chk (
  .src_clk_i   (src_clk_i),
  .src_rst_ni  (src_rst_ni),
  .dst_clk_i   (dst_clk_i),
  .dst_rst_ni  (dst_rst_ni),
  .src_valid_i (src_valid_i),
  .src_busy_o  (src_busy_o),
  .src_accept  (src_accept),
  .ack_sync    (ack_sync),
  .hold_word   (hold_word),
  .dst_data_o  (dst_data_o),
  .dst_valid_o (dst_valid_o)
);

// File: tb/word_cdc_sync_tb_top.sv
`timescale 1ns/1ps
module word_cdc_sync_tb_top;
  localparam int W = 16;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst_n = 1'b0;
  logic         dst_rst_n = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_valid = 1'b0;
  logic         src_busy;
  logic [W-1:0] dst_data;
  logic         dst_valid;

  always #2.5 src_clk = ~src_clk;  // 200 MHz source
  always #3.5 dst_clk = ~dst_clk;  // unrelated destination

  word_cdc_sync #(.WIDTH(W), .STAGES(2)) dut_i (
    .src_clk_i   (src_clk),
    .src_rst_ni  (src_rst_n),
    .src_data_i  (src_data),
    .src_valid_i (src_valid),
    .src_busy_o  (src_busy),
    .dst_clk_i   (dst_clk),
    .dst_rst_ni  (dst_rst_n),
    .dst_data_o  (dst_data),
    .dst_valid_o (dst_valid)
  );

  int n_chk = 0;
  int n_err = 0;
  int acc_cnt = 0;
  int dlv_cnt = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_data = '0;
  logic prev_valid = 1'b0;
  logic last_acc = 1'b0;
  logic prev_busy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // driver: one source cycle per call, acceptance judged from busy only
  task automatic drive_cycle(input logic v, input logic [W-1:0] d);
    @(negedge src_clk);
    if (last_acc) chk(src_busy === 1'b1, "R3 busy after take", {31'd0, src_busy}, 32'd1);
    if (prev_busy && !src_busy) chk(dlv_cnt == acc_cnt, "R7 busy fell before delivery", dlv_cnt, acc_cnt);
    prev_busy = src_busy;
    src_valid = v;
    src_data  = d;
    last_acc  = v && !src_busy;
    if (last_acc) begin
      exp_q.push_back(d);
      acc_cnt++;
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // monitor: scoreboard pop on every delivery pulse
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        chk(!prev_valid, "R2 pulse longer than one cycle", {31'd0, prev_valid}, 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 R6 unexpected delivery", {16'd0, dst_data}, 32'd0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(dst_data === e, "R2 R6 delivered word", {16'd0, dst_data}, {16'd0, e});
        end
        last_data = dst_data;
        dlv_cnt++;
      end else begin
        chk(dst_data === last_data, "R5 output held", {16'd0, dst_data}, {16'd0, last_data});
      end
      prev_valid = dst_valid;
    end
  end

  task automatic main_seq();
    int acc0;
    repeat (4) @(negedge src_clk);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    @(negedge src_clk);
    chk(src_busy === 1'b0, "R1 busy after reset", {31'd0, src_busy}, 32'd0);
    @(negedge dst_clk);
    chk(dst_data === '0, "R1 data after reset", {16'd0, dst_data}, 32'd0);
    chk(dst_valid === 1'b0, "R1 valid after reset", {31'd0, dst_valid}, 32'd0);

    // single words incl. extremes
    drive_cycle(1'b1, 16'hA5C3);
    repeat (20) drive_cycle(1'b0, 16'h0000);
    chk(dlv_cnt == 1, "R2 single word delivered once", dlv_cnt, 32'd1);
    drive_cycle(1'b1, 16'hFFFF);
    repeat (20) drive_cycle(1'b0, 16'h0000);
    drive_cycle(1'b1, 16'h0000);
    repeat (20) drive_cycle(1'b0, 16'h0000);
    chk(dst_data === 16'h0000, "R2 zero word", {16'd0, dst_data}, 32'd0);

    // offers while busy must vanish
    acc0 = acc_cnt;
    drive_cycle(1'b1, 16'h1111);
    repeat (3) drive_cycle(1'b1, 16'h2222);
    drive_cycle(1'b0, 16'h3333);
    repeat (20) drive_cycle(1'b0, 16'h3333);
    chk(acc_cnt - acc0 == 1, "R4 only one take", acc_cnt - acc0, 32'd1);
    chk(dst_data === 16'h1111, "R4 busy offer ignored", {16'd0, dst_data}, 32'h1111);

    // continuous offers: take coincides with busy release
    acc0 = acc_cnt;
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      drive_cycle(1'b1, lfsr);
    end
    chk(acc_cnt - acc0 > 10, "R3 back-to-back takes", acc_cnt - acc0, 32'd11);

    // sparse offers
    for (int i = 0; i < 400; i++) begin
      step_lfsr();
      drive_cycle(lfsr[3] & lfsr[7], lfsr ^ 16'h5A5A);
    end

    repeat (40) drive_cycle(1'b0, 16'h0000);
    chk(exp_q.size() == 0, "R6 no word lost", exp_q.size(), 32'd0);
    chk(dlv_cnt == acc_cnt, "R6 delivered count", dlv_cnt, acc_cnt);
    chk(src_busy === 1'b0, "R7 idle at end", {31'd0, src_busy}, 32'd0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge src_clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R6 act=hung exp=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule